// File: doc/BRIEF.md
# SWD register access controller

This block is the host side of one complete serial-wire debug register access. A single `start` pulse loads the access parameters: the port select (debug or access port), the two address bits, read or write, the write word and a turnaround setting. The block then runs the whole exchange on the two-wire line and ends with a one-cycle `done` pulse. The exchange has five parts: an 8-bit request, a turnaround, a 3-bit acknowledge, an optional 33-bit data phase and a closing turnaround. The acknowledge code, the read word and a parity-error flag are held on the outputs until the next access starts.

Internally a sequencer walks the phases and gives each one to a bit engine. For each phase the engine receives a bit count, a drive flag and a transmit word. It makes one SWCLK period per bit: the line is updated while the clock is low, and the input is captured on the system-clock edge that raises the clock. Between accesses the clock rests high and the host drives the data line high. Retrying after WAIT or FAULT is left to the user of the block.

The sequencer has eight states:
- IDLE waits for `start`.
- REQ sends the request.
- TRN_A is the turnaround after the request.
- ACK receives the acknowledge.
- TRN_B is the turnaround after a write OK or after any refused access.
- WDAT sends the write data.
- RDAT receives the read data.
- TRN_C is the turnaround after read data.

The transitions are:
- IDLE→REQ on `start`.
- REQ→TRN_A when the request bits are finished.
- TRN_A→ACK when the turnaround is finished.
- ACK→RDAT on a read with OK.
- ACK→TRN_B otherwise.
- TRN_B→WDAT if the acknowledge was OK, else TRN_B→IDLE.
- WDAT→IDLE when the data is finished.
- RDAT→TRN_C when the data is finished.
- TRN_C→IDLE when the turnaround is finished.

Each entry into IDLE from another state produces `done`.

Top module: `swd_xact`

## Requirements
- R1: After reset, `swclk`=1, `swdio_out`=1, `swdio_oe`=1, `busy`=0, `done`=0, `ack`=0, `rdata`=0 and `par_err`=0.
- R2: The request is 8 bits sent LSB first with `swdio_oe`=1. The bits are: bit0=1, bit1=`ap_sel`, bit2=`rnw`, bit3=`addr[0]`, bit4=`addr[1]`, bit5=XOR of bits 1..4, bit6=0, bit7=1.
- R3: `swdio_out` changes only while `swclk` is low during an access. Each bit is taken from `swdio_in` as `swclk` rises, and each bit lasts exactly one SWCLK period.
- R4: Every turnaround lasts `trn_cfg`+1 SWCLK periods, so the value 0 gives one period. The host releases the line (`swdio_oe`=0) for each turnaround and for the three acknowledge bits.
- R5: `ack` holds the three acknowledge bits with the first received bit in `ack[0]`. OK is 3'b001, WAIT is 3'b010 and FAULT is 3'b100. 3'b111 means that no target drove the line.
- R6: If `ack` is any value other than 3'b001, no data phase takes place: the access ends after one more turnaround, with 11+2×(`trn_cfg`+1) SWCLK periods in total.
- R7: A write with OK inserts a turnaround and then drives 33 bits with `swdio_oe`=1. These are `wdata` LSB first, then a parity bit that is 1 when `wdata` has an odd number of ones.
- R8: A read with OK receives 33 released bits. `rdata` takes the first 32. `par_err` is set when the 33rd bit differs from the XOR of those 32. `par_err` is cleared at every start and is never set by a write or by a refused access; `rdata` changes only on a read with OK.
- R9: A read with OK is followed by one turnaround before completion. `done` is a single-cycle pulse with `busy`=0, `swclk`=1 and `swdio_oe`=1.
- R10: `start` is ignored while `busy`=1; the parameters of the running access stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an access (taken in IDLE only) |
| ap_sel | input | 1 | 1 selects the access port, 0 the debug port |
| rnw | input | 1 | 1 read, 0 write |
| addr | input | 2 | Register address bits [3:2] |
| wdata | input | 32 | Word to write |
| trn_cfg | input | 2 | Turnaround length minus one |
| swdio_in | input | 1 | Data line as seen by the host |
| swclk | output | 1 | Serial clock to the target |
| swdio_out | output | 1 | Data value the host drives |
| swdio_oe | output | 1 | 1 when the host drives the data line |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle pulse at the end of an access |
| ack | output | 3 | Acknowledge code of the last access |
| rdata | output | 32 | Word from the last read with OK |
| par_err | output | 1 | Read parity mismatch in the last access |

## Verification
The bench counts SWCLK rising edges per access and compares the count with the phase lengths. A sequencer that skipped or doubled a turnaround, or went on to a data phase after WAIT, FAULT or an undriven line, would show the wrong count. It also checks `swdio_oe` bit by bit, which exposes a host that takes back the line too early after the request or during read data. It also catches a write that leaves out the turnaround before its data. Reads are repeated with a corrupted parity bit, and accesses are run with several turnaround lengths and with `start` pulsed mid-access. A wrong parity polarity, a lost length setting or a request rebuilt from the new inputs shows up as a mismatched result or request bit.

// File: rtl/swdt_pkg.sv
package swdt_pkg;

    typedef enum logic [2:0] {
        C_IDLE, C_REQ, C_TRN_A, C_ACK, C_TRN_B, C_WDAT, C_RDAT, C_TRN_C
    } seq_state_t;

    typedef enum logic [1:0] {
        E_IDLE, E_LOW, E_HIGH
    } eng_state_t;

    localparam logic [2:0] ACK_OK    = 3'b001;
    localparam logic [2:0] ACK_WAIT  = 3'b010;
    localparam logic [2:0] ACK_FAULT = 3'b100;
    localparam logic [2:0] ACK_NONE  = 3'b111;

    function automatic logic [7:0] req_byte(input logic ap, input logic rd,
                                            input logic [1:0] a);
        return {1'b1, 1'b0, ap ^ rd ^ a[1] ^ a[0], a[1], a[0], rd, ap, 1'b1};
    endfunction

endpackage

// File: rtl/swdt_engine.sv
module swdt_engine
    import swdt_pkg::*;
#(
    parameter int NMAX     = 33,
    parameter int CLK_HALF = 2,
    localparam int CW      = $clog2(NMAX + 1),
    localparam int DW      = $clog2(CLK_HALF) + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            go,
    input  logic [CW-1:0]   nbits,
    input  logic            drive,
    input  logic [NMAX-1:0] tx,
    input  logic            sin,
    output logic            fin,
    output logic [NMAX-1:0] rx,
    output logic            sclk,
    output logic            sdo,
    output logic            soe
);

    eng_state_t      st_q, st_d;
    logic [DW-1:0]   div_q;
    logic [CW-1:0]   left_q;
    logic [NMAX-1:0] txs_q;
    logic            drv_q;
    logic            half_end;

    assign half_end = (div_q == DW'(CLK_HALF - 1));

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            E_IDLE: if (go) st_d = E_LOW;
            E_LOW:  if (half_end) st_d = E_HIGH;
            E_HIGH: if (half_end) st_d = (left_q == CW'(1)) ? E_IDLE : E_LOW;
            default: st_d = E_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= E_IDLE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q  <= '0;
            left_q <= '0;
            txs_q  <= '0;
            drv_q  <= 1'b0;
            rx     <= '0;
            fin    <= 1'b0;
            sclk   <= 1'b1;
            sdo    <= 1'b1;
            soe    <= 1'b1;
        end else begin
            fin <= 1'b0;
            unique case (st_q)
                E_IDLE: if (go) begin
                    txs_q  <= tx;
                    left_q <= nbits;
                    drv_q  <= drive;
                    div_q  <= '0;
                    sclk   <= 1'b0;
                    sdo    <= drive ? tx[0] : 1'b1;
                    soe    <= drive;
                end
                E_LOW: begin
                    if (half_end) begin
                        rx    <= {sin, rx[NMAX-1:1]};
                        sclk  <= 1'b1;
                        div_q <= '0;
                    end else begin
                        div_q <= div_q + DW'(1);
                    end
                end
                E_HIGH: begin
                    if (half_end) begin
                        div_q <= '0;
                        if (left_q == CW'(1)) begin
                            fin <= 1'b1;
                            sdo <= 1'b1;
                            soe <= 1'b1;
                        end else begin
                            txs_q  <= txs_q >> 1;
                            sdo    <= drv_q ? txs_q[1] : 1'b1;
                            left_q <= left_q - CW'(1);
                            sclk   <= 1'b0;
                        end
                    end else begin
                        div_q <= div_q + DW'(1);
                    end
                end
                default: ;
            endcase
        end
    end

    // R3
    data_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != E_IDLE && !$stable(sdo)) |-> !sclk);

endmodule

// File: rtl/swdt_seq.sv
module swdt_seq
    import swdt_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int TRN_W  = 2,
    localparam int NMAX  = DATA_W + 1,
    localparam int CW    = $clog2(NMAX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              ap_sel,
    input  logic              rnw,
    input  logic [1:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [TRN_W-1:0]  trn_cfg,
    input  logic              fin,
    input  logic [NMAX-1:0]   rx,
    output logic              go,
    output logic [CW-1:0]     nbits,
    output logic              drive,
    output logic [NMAX-1:0]   tx,
    output logic              busy,
    output logic              done,
    output logic [2:0]        ack,
    output logic [DATA_W-1:0] rdata,
    output logic              par_err
);

    seq_state_t        st_q, st_d;
    logic              ap_q, rnw_q;
    logic [1:0]        addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [TRN_W-1:0]  trn_q;
    logic [2:0]        rx_ack;

    assign rx_ack = rx[NMAX-1:NMAX-3];
    assign busy   = (st_q != C_IDLE);

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            C_IDLE:  if (start) st_d = C_REQ;
            C_REQ:   if (fin) st_d = C_TRN_A;
            C_TRN_A: if (fin) st_d = C_ACK;
            C_ACK:   if (fin) st_d = (rx_ack == ACK_OK && rnw_q) ? C_RDAT : C_TRN_B;
            C_TRN_B: if (fin) st_d = (ack == ACK_OK) ? C_WDAT : C_IDLE;
            C_WDAT:  if (fin) st_d = C_IDLE;
            C_RDAT:  if (fin) st_d = C_TRN_C;
            C_TRN_C: if (fin) st_d = C_IDLE;
            default: st_d = C_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= C_IDLE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            go      <= 1'b0;
            done    <= 1'b0;
            ap_q    <= 1'b0;
            rnw_q   <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
            trn_q   <= '0;
            ack     <= '0;
            rdata   <= '0;
            par_err <= 1'b0;
        end else begin
            go   <= (st_d != st_q) && (st_d != C_IDLE);
            done <= (st_q != C_IDLE) && (st_d == C_IDLE);
            if (st_q == C_IDLE && start) begin
                ap_q    <= ap_sel;
                rnw_q   <= rnw;
                addr_q  <= addr;
                wdata_q <= wdata;
                trn_q   <= trn_cfg;
                ack     <= '0;
                par_err <= 1'b0;
            end
            if (st_q == C_ACK && fin) ack <= rx_ack;
            if (st_q == C_RDAT && fin) begin
                rdata   <= rx[DATA_W-1:0];
                par_err <= rx[NMAX-1] ^ (^rx[DATA_W-1:0]);
            end
        end
    end

    always_comb begin
        nbits = CW'(trn_q) + CW'(1);
        drive = 1'b0;
        tx    = '0;
        unique case (st_q)
            C_REQ:  begin nbits = CW'(8); drive = 1'b1;
                          tx = NMAX'(req_byte(ap_q, rnw_q, addr_q)); end
            C_ACK:  nbits = CW'(3);
            C_WDAT: begin nbits = CW'(NMAX); drive = 1'b1;
                          tx = {^wdata_q, wdata_q}; end
            C_RDAT: nbits = CW'(NMAX);
            default: ;
        endcase
    end

    // R6
    data_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == C_WDAT || st_q == C_RDAT) |-> (ack == ACK_OK));

    // R8
    perr_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        par_err |-> rnw_q);

    // R10
    hold_params_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(ap_q) && $stable(addr_q) && $stable(trn_q)));

endmodule

// File: rtl/swd_xact.sv
module swd_xact
    import swdt_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int TRN_W    = 2,
    parameter int CLK_HALF = 2,
    localparam int NMAX    = DATA_W + 1,
    localparam int CW      = $clog2(NMAX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              ap_sel,
    input  logic              rnw,
    input  logic [1:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [TRN_W-1:0]  trn_cfg,
    input  logic              swdio_in,
    output logic              swclk,
    output logic              swdio_out,
    output logic              swdio_oe,
    output logic              busy,
    output logic              done,
    output logic [2:0]        ack,
    output logic [DATA_W-1:0] rdata,
    output logic              par_err
);

    logic            go, drive, fin;
    logic [CW-1:0]   nbits;
    logic [NMAX-1:0] tx, rx;

    swdt_seq #(.DATA_W(DATA_W), .TRN_W(TRN_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .ap_sel(ap_sel), .rnw(rnw),
        .addr(addr), .wdata(wdata), .trn_cfg(trn_cfg), .fin(fin), .rx(rx),
        .go(go), .nbits(nbits), .drive(drive), .tx(tx), .busy(busy),
        .done(done), .ack(ack), .rdata(rdata), .par_err(par_err)
    );

    swdt_engine #(.NMAX(NMAX), .CLK_HALF(CLK_HALF)) u_eng (
        .clk(clk), .rst_n(rst_n), .go(go), .nbits(nbits), .drive(drive),
        .tx(tx), .sin(swdio_in), .fin(fin), .rx(rx), .sclk(swclk),
        .sdo(swdio_out), .soe(swdio_oe)
    );

    // R9
    done_own_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (swdio_oe && !busy && swclk));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

// File: tb/swd_xact_test.sv
module swd_xact_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0, ap_sel = 1'b0, rnw = 1'b0;
    logic [1:0]  addr = '0, trn_cfg = '0;
    logic [31:0] wdata = '0;
    logic        swdio_in = 1'b1;
    logic        swclk, swdio_out, swdio_oe, busy, done, par_err;
    logic [2:0]  ack;
    logic [31:0] rdata;

    int checks = 0, fails = 0;
    logic [35:0] expq[$];
    logic [63:0] resp, out_cap, oe_cap;
    int          edges = 0;
    logic        cap_on = 1'b0;
    logic [31:0] last_rd = '0;

    always #5 clk = ~clk;

    swd_xact uut (
        .clk(clk), .rst_n(rst_n), .start(start), .ap_sel(ap_sel), .rnw(rnw),
        .addr(addr), .wdata(wdata), .trn_cfg(trn_cfg), .swdio_in(swdio_in),
        .swclk(swclk), .swdio_out(swdio_out), .swdio_oe(swdio_oe), .busy(busy),
        .done(done), .ack(ack), .rdata(rdata), .par_err(par_err)
    );

    task automatic chk(input logic ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // target model: record each rising edge, present next response bit
    always @(posedge swclk) begin
        if (cap_on) begin
            out_cap[edges] = swdio_out;
            oe_cap[edges]  = swdio_oe;
            edges = edges + 1;
            #1 swdio_in = resp[edges];
        end
    end

    // monitor: pop expected result on done
    always @(negedge clk) begin
        if (rst_n && done) begin
            logic [35:0] e;
            if (expq.size() == 0) begin
                chk(1'b0, "R9 unexpected done", 0, 0);
            end else begin
                e = expq.pop_front();
                chk(ack == e[34:32], "R5 ack", ack, e[34:32]);
                chk(rdata == e[31:0], "R8 rdata", rdata, e[31:0]);
                chk(par_err == e[35], "R8 par_err", par_err, e[35]);
                chk(swdio_oe && !busy && swclk, "R9 line owned at done",
                    {swdio_oe, busy, swclk}, 3'b101);
            end
        end
    end

    task automatic access(input logic ap, input logic rd, input logic [1:0] a,
                          input logic [31:0] wd, input logic [1:0] tc,
                          input logic [2:0] ackv, input logic [31:0] rdv,
                          input logic bad_par, input logic poke);
        int t, n, b;
        logic ok;
        logic [7:0] rq;
        t  = int'(tc) + 1;
        ok = (ackv == 3'b001);
        rq = {1'b1, 1'b0, ap ^ rd ^ a[1] ^ a[0], a[1], a[0], rd, ap, 1'b1};
        resp = '1;
        for (int i = 0; i < 3; i++) resp[8 + t + i] = ackv[i];
        if (rd && ok) begin
            for (int i = 0; i < 32; i++) resp[11 + t + i] = rdv[i];
            resp[11 + t + 32] = (^rdv) ^ bad_par;
            last_rd = rdv;
        end
        n = 11 + t + (ok ? 33 + t : t);
        expq.push_back({rd && ok && bad_par, ackv, last_rd});
        edges = 0; out_cap = '0; oe_cap = '0; cap_on = 1'b1; swdio_in = resp[0];
        @(negedge clk);
        ap_sel = ap; rnw = rd; addr = a; wdata = wd; trn_cfg = tc; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            repeat (30) @(negedge clk);
            ap_sel = ~ap; addr = ~a; rnw = ~rd; trn_cfg = ~tc; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (!done) @(negedge clk);
        cap_on = 1'b0;
        @(negedge clk);
        chk(edges == n, "R4 R6 SWCLK period count", edges, n);
        chk(out_cap[7:0] == rq && oe_cap[7:0] == 8'hFF, "R2 request bits",
            {oe_cap[7:0], out_cap[7:0]}, {8'hFF, rq});
        b = 0;
        for (int i = 8; i < 11 + t; i++) b += oe_cap[i];
        chk(b == 0, "R4 release for turnaround and ack", b, 0);
        if (!rd && ok) begin
            b = 0;
            for (int i = 11 + t; i < 11 + 2 * t; i++) b += oe_cap[i];
            chk(b == 0, "R7 turnaround before write data", b, 0);
            chk(oe_cap[11+2*t +: 33] == {33{1'b1}}, "R7 host drives data",
                oe_cap[11+2*t +: 33], {33{1'b1}});
            chk(out_cap[11+2*t +: 33] == {^wd, wd}, "R7 write data and parity",
                out_cap[11+2*t +: 33], {^wd, wd});
        end
        if (rd && ok) begin
            b = 0;
            for (int i = 11 + t; i < n; i++) b += oe_cap[i];
            chk(b == 0, "R8 R9 released through data and final turnaround", b, 0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk({swclk, swdio_out, swdio_oe, busy, done, ack, rdata, par_err} ==
            {5'b11100, 3'b000, 32'h0, 1'b0}, "R1 reset state",
            {swclk, swdio_out, swdio_oe, busy, done, ack, par_err}, 9'b111000000);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        access(1'b0, 1'b1, 2'b00, 32'h0, 2'd0, 3'b001, 32'h2BA01477, 1'b0, 1'b0);
        access(1'b1, 1'b0, 2'b01, 32'hA2000012, 2'd0, 3'b001, 32'h0, 1'b0, 1'b0);
        access(1'b1, 1'b1, 2'b11, 32'h0, 2'd1, 3'b001, 32'hFFFF0001, 1'b1, 1'b0);
        access(1'b0, 1'b0, 2'b10, 32'h5, 2'd2, 3'b010, 32'h0, 1'b0, 1'b0);
        access(1'b0, 1'b1, 2'b01, 32'h0, 2'd0, 3'b100, 32'h12345678, 1'b0, 1'b0);
        access(1'b1, 1'b1, 2'b10, 32'h0, 2'd3, 3'b111, 32'hDEADBEEF, 1'b0, 1'b0);
        access(1'b0, 1'b0, 2'b11, 32'hFFFFFFFF, 2'd3, 3'b001, 32'h0, 1'b0, 1'b0);
        access(1'b1, 1'b1, 2'b01, 32'h0, 2'd0, 3'b001, 32'h00000007, 1'b1, 1'b0);
        // R10: start pulsed mid-access with different parameters
        access(1'b0, 1'b1, 2'b10, 32'h0, 2'd1, 3'b001, 32'h80000000, 1'b0, 1'b1);
        repeat (40) @(negedge clk);
        chk(!busy && expq.size() == 0, "R10 no access launched by ignored start",
            {busy, 8'(expq.size())}, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        #1000000;
        checks++; fails++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule